// File: doc/BRIEF.md
# Pseudo-Random Self-Test Wrapper for a Majority Gate

This block tests itself. A small controller runs the test sequence. A three-stage shift register with XOR feedback produces every nonzero three-bit input pattern once. An analyzer applies each pattern to two instances of a three-input majority gate. One instance is always healthy. The other can carry a bridging defect. The analyzer counts the patterns on which the two outputs disagree.

A run begins when `start` is pulsed while the block is idle. `fault_enable` is sampled in that cycle and decides whether the second copy is defective for the whole run. The block stays busy for seven clocks, applying one pattern per clock. It then raises `done` for a single cycle. At that point the mismatch count and the `detected` flag are final, and they hold until the next accepted start. The applied pattern is visible on `stim` so that the stimulus order can be observed.

Top module: `bist_top`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `detected` and `mismatch_cnt` are all zero, and `stim` holds the seed 3'b100.
- R2: `stim` carries A in bit 2, B in bit 1 and C in bit 0. In the seven busy cycles it shows 100, 010, 101, 110, 111, 011, 001, in that order, and it is never 000.
- R3: The healthy output is the majority of A, B and C. The defective output is B AND C. `mismatch_cnt` rises by one, one clock later, for each applied pattern where the two outputs differ.
- R4: After the clock edge that accepts `start`, `busy` is high for exactly seven cycles.
- R5: `done` is high for exactly one cycle, which is the cycle right after the last busy cycle. `busy` is low in that cycle.
- R6: A `start` pulse seen while `busy` is high is ignored. The run length and the results do not change.
- R7: `fault_enable` is sampled only when `start` is accepted. When it is sampled low, the final count is zero and `detected` is low, whatever `fault_enable` does during the run.
- R8: When `fault_enable` is sampled high, the final count is 2 and `detected` is high. `detected` equals (count != 0) while `done` is high. Count and flag hold until the next accepted start.
- R9: A `start` in the `done` cycle is accepted. The next cycle is busy, with the count cleared to zero and `stim` back at the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only when idle |
| fault_enable | input | 1 | Inject the bridge defect in the second copy for this run |
| busy | output | 1 | Patterns are being applied |
| done | output | 1 | One-cycle end-of-run pulse |
| detected | output | 1 | The last run saw at least one mismatch |
| mismatch_cnt | output | $clog2(NPAT+1) | Number of differing patterns in the last run |
| stim | output | 3 | Pattern currently applied (A,B,C) |

## Verification
Two functions can fall in the same cycle: the end-of-run `done` pulse and the acceptance of a new `start`. The bench provokes this by raising `start` exactly in the `done` cycle. It then checks three things: the `done` pulse still lasts one cycle, the next cycle is busy with a cleared count and the seed on `stim`, and the second run yields its own expected count. Random `start` pulses and random `fault_enable` toggles during busy cycles check that neither can cut a run short nor change its result.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int          STAGES  = 3;
  localparam int          NPAT    = 7;
  localparam logic [2:0]  SEED    = 3'b100; // {S0,S1,S2}

  // state is {S0,S1,S2}; S0 drives A (bit 2)
  function automatic logic [2:0] lfsr_step(input logic [2:0] s);
    logic s0, s1, s2;
    s0 = s[2]; s1 = s[1]; s2 = s[0];
    return {s1 ^ s2, s0, s1};
  endfunction
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr
  import bist_pkg::*;
#(
  parameter logic [STAGES-1:0] INIT = SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [STAGES-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)       state <= INIT;
    else if (load) state <= INIT;
    else if (step) state <= lfsr_step(state);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R2
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> state != $past(state)); // R2
endmodule

// File: rtl/bist_cut.sv
module bist_cut #(
  parameter bit BRIDGED = 1'b0
) (
  input  logic [2:0] abc,
  input  logic       defect_on,
  output logic       y
);
  logic a, b, c, healthy;
  assign a = abc[2];
  assign b = abc[1];
  assign c = abc[0];
  assign healthy = (a & b) | (a & c) | (b & c);

  generate
    if (BRIDGED) begin : g_bridge
      // the bridge pulls the A-dependent terms low, leaving only B&C
      assign y = defect_on ? (b & c) : healthy;
    end else begin : g_clean
      logic unused_def;
      assign unused_def = defect_on;
      assign y = healthy;
    end
  endgenerate
endmodule

// File: rtl/bist_resp.sv
module bist_resp
  import bist_pkg::*;
#(
  parameter int N    = NPAT,
  localparam int CW  = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          last,
  input  logic          fault_enable,
  input  logic [2:0]    stim,
  output logic [CW-1:0] cnt,
  output logic          detected
);
  logic fault_lat;
  logic y_good, y_bad, miss;
  logic [CW-1:0] cnt_nxt;

  bist_cut #(.BRIDGED(1'b0)) u_good (.abc(stim), .defect_on(1'b0),      .y(y_good));
  bist_cut #(.BRIDGED(1'b1)) u_bad  (.abc(stim), .defect_on(fault_lat), .y(y_bad));

  assign miss    = y_good ^ y_bad;
  assign cnt_nxt = cnt + CW'(miss);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_lat <= 1'b0;
      cnt       <= '0;
      detected  <= 1'b0;
    end else if (load) begin
      fault_lat <= fault_enable;
      cnt       <= '0;
      detected  <= 1'b0;
    end else if (step) begin
      cnt <= cnt_nxt;
      if (last) detected <= (cnt_nxt != '0);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(N)); // R3
  AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !fault_lat |-> cnt == '0); // R7
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> cnt >= $past(cnt)); // R3
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int N   = NPAT,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic last
);
  logic [IW-1:0] idx;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (idx == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done || $past(load)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> idx <= IW'(N - 1)); // R4
endmodule

// File: rtl/bist_top.sv
module bist_top
  import bist_pkg::*;
#(
  parameter int N = NPAT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       fault_enable,
  output logic                       busy,
  output logic                       done,
  output logic                       detected,
  output logic [$clog2(N+1)-1:0]     mismatch_cnt,
  output logic [2:0]                 stim
);
  logic load, step, last;

  bist_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .load(load), .step(step), .last(last)
  );

  bist_lfsr u_lfsr (
    .clk(clk), .rst(rst), .load(load), .step(step), .state(stim)
  );

  bist_resp #(.N(N)) u_resp (
    .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
    .fault_enable(fault_enable), .stim(stim),
    .cnt(mismatch_cnt), .detected(detected)
  );

  AST_DETECT_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> detected == (mismatch_cnt != '0)); // R8
  AST_SEED_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (stim == SEED && mismatch_cnt == '0)); // R9
endmodule

// File: tb/bist_top_tb.sv
`timescale 1ns/1ps
module bist_top_tb;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, fault_enable = 1'b0;
  logic busy, done, detected;
  logic [2:0] mismatch_cnt, stim;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bist_top u_dut (
    .clk(clk), .rst(rst), .start(start), .fault_enable(fault_enable),
    .busy(busy), .done(done), .detected(detected),
    .mismatch_cnt(mismatch_cnt), .stim(stim)
  );

  localparam logic [2:0] SEQ [7] = '{3'b100, 3'b010, 3'b101, 3'b110,
                                     3'b111, 3'b011, 3'b001};

  function automatic bit maj3(input logic [2:0] p);
    return (p[2] + p[1] + p[0]) >= 2;
  endfunction
  function automatic bit bridged(input logic [2:0] p);
    return p[1] & p[0];
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // expects start already high at the preceding edge when b2b is set
  task automatic run(input bit fe, input bit noisy, input bit b2b);
    int exp_cnt = 0;
    if (!b2b) begin
      start = 1'b1; fault_enable = fe;
      @(negedge clk);
    end
    start = 1'b0;
    for (int k = 0; k < 7; k++) begin
      chk("R4 busy", busy, 1);
      chk("R5 done low while busy", done, 0);
      chk("R2 stim", stim, SEQ[k]);
      chk(k == 0 ? "R9 count cleared" : "R3 running count", mismatch_cnt, exp_cnt);
      if (fe && (maj3(SEQ[k]) != bridged(SEQ[k]))) exp_cnt++;
      if (noisy) begin
        start = 1'($urandom % 2);          // R6 ignored
        fault_enable = 1'($urandom % 2);   // R7 not resampled
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R5 done pulse", done, 1);
    chk("R5 busy low at done", busy, 0);
    chk(fe ? "R8 count" : "R7 count", mismatch_cnt, exp_cnt);
    chk(fe ? "R8 detected" : "R7 detected", detected, exp_cnt != 0);
    chk("R8 expected total", exp_cnt, fe ? 2 : 0);
  endtask

  task automatic check_hold(input bit fe);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R4 idle after run", busy, 0);
    chk("R8 count held", mismatch_cnt, fe ? 2 : 0);
    chk("R8 detected held", detected, fe);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 detected", detected, 0);
    chk("R1 count", mismatch_cnt, 0);
    chk("R1 stim seed", stim, 3'b100);

    run(1'b0, 1'b0, 1'b0); check_hold(1'b0);
    run(1'b1, 1'b0, 1'b0); check_hold(1'b1);
    run(1'b0, 1'b1, 1'b0); check_hold(1'b0);
    run(1'b1, 1'b1, 1'b0); check_hold(1'b1);

    // R9: start in the done cycle
    run(1'b1, 1'b0, 1'b0);
    start = 1'b1; fault_enable = 1'b0;
    @(negedge clk);
    chk("R9 busy after b2b start", busy, 1);
    chk("R9 done cleared", done, 0);
    chk("R9 stim reseeded", stim, 3'b100);
    run(1'b0, 1'b0, 1'b1); check_hold(1'b0);

    for (int i = 0; i < 20; i++) begin
      bit fe = 1'($urandom % 2);
      repeat ($urandom % 3) @(negedge clk);
      run(fe, 1'b1, 1'b0);
      check_hold(fe);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule